// File: doc/BRIEF.md
# Strided Vector Memory Access Sequencer

This block carries out a single strided vector load or store. A command gives a base byte address, a signed byte stride, an element count from 0 to `MAX_VL`, an element width of 8, 16, 32 or 64 bits, and an optional per-element mask. The block walks the elements in ascending order. The byte address of element i is the base plus i times the stride. For each active element it issues one access on a 64-bit valid/ready request port. The byte enables and the write-data lanes are placed by the low three address bits.

Loads return data on a response port. The block extracts the element from the same byte lanes and writes it into an internal packed vector. That vector is seeded from `vec_i` when the command starts, so masked-off elements keep their old value. Stores read each element from the same packed vector, which `vec_i` also seeds. The request port has one access in flight at most. A store completes on its handshake. A load completes when its response arrives.

The enclosing load/store unit pulses `start_i` while the block is idle and waits for `done_o`. It then reads the loaded vector from `vec_o`.

Top module: `strided_vec_seq`

## Requirements
- R1: Element i accesses byte address base + i*stride, computed modulo 2^ADDR_W. The stride counts bytes and does not depend on element width. For example, 8-bit elements with stride 3 from base B access B, B+3, B+6 and B+9.
- R2: The stride is two's complement. A negative stride places element 0 at the base and each later element at a lower address.
- R3: A zero stride still issues one access per active element, all to the same address. On a load, every element receives the same value.
- R4: `ew_i` selects the element width: 0 for 8 bits, 1 for 16, 2 for 32, 3 for 64. In `vec_i` and `vec_o`, element i of width W occupies bits [i*W +: W]. A stride equal to the element size reproduces a contiguous block of memory in the vector.
- R5: The byte enable of a request is the element's byte mask (0x01, 0x03, 0x0F or 0xFF) shifted left by addr[2:0]. Store data is shifted left by 8*addr[2:0]. Load data is taken from the same byte lanes and zero-extended.
- R6: When `mask_en_i` is 1, element i is active only if `mask_i[i]` is 1. An inactive load element keeps its seeded value in `vec_o`. An inactive store element issues no request, so memory is unchanged.
- R7: An active element whose address is not a multiple of its size issues no request. It ends the command with `done_o`, and `err_o` goes high. `err_o` stays high until the next command is accepted, which clears it.
- R8: Only one request is outstanding at a time. After a load handshake, no new request is raised until the response has been taken.
- R9: A command with length 0 raises `done_o` in the cycle after `start_i` and issues no request.
- R10: `start_i` is ignored while `busy_o` is high. The running command's addresses are not affected.
- R11: `done_o` is a one-cycle pulse raised after the last element completes. In that cycle `busy_o` is already low.
- R12: While `req_valid_o` is high and `req_ready_i` is low, the request stays valid and its address, byte enables, write flag and data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command start pulse, taken only when idle |
| is_store_i | input | 1 | 1 for a store, 0 for a load |
| base_addr_i | input | ADDR_W | Byte address of element 0 |
| stride_i | input | ADDR_W | Signed byte stride |
| vl_i | input | $clog2(MAX_VL+1) | Element count |
| ew_i | input | 2 | Element width code |
| mask_en_i | input | 1 | Enables per-element masking |
| mask_i | input | MAX_VL | Mask bits, bit i for element i |
| vec_i | input | MAX_VL*64 | Store source and seed for the load destination |
| vec_o | output | MAX_VL*64 | Packed vector after the command |
| busy_o | output | 1 | A command is running |
| done_o | output | 1 | Command completion pulse |
| err_o | output | 1 | The last command stopped on a misaligned element |
| req_valid_o | output | 1 | Memory request valid |
| req_ready_i | input | 1 | Memory request accepted |
| req_we_o | output | 1 | Request is a write |
| req_addr_o | output | ADDR_W | Request byte address |
| req_be_o | output | 8 | Request byte enables |
| req_wdata_o | output | 64 | Request write data |
| rsp_valid_i | input | 1 | Load response valid |
| rsp_rdata_i | input | 64 | Load response data, 64-bit word |

## Verification
The bench uses the defaults, ADDR_W = 32 and MAX_VL = 16. This allows a full 16-element zero-stride load and mask patterns across all element positions. It also covers a negative stride that depends on 32-bit wrap-around, and 64-bit elements 40 bytes apart, wider than the bus. The memory model can hold `req_ready_i` low for several cycles, which exercises request stability. It always returns load data a cycle after the handshake, which exposes any second request raised while a load is in flight.

// File: rtl/strided_pkg.sv
package strided_pkg;
  typedef enum logic [1:0] {EW8 = 2'd0, EW16 = 2'd1, EW32 = 2'd2, EW64 = 2'd3} ew_e;
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_st_e;
endpackage

// File: rtl/strided_addr_gen.sv
module strided_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;

  // running sum; two's complement wrap gives negative strides for free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      idx_q  <= '0;
    end else if (step_i) begin
      addr_q <= addr_q + stride_i;
      idx_q  <= idx_q + IDX_W'(1);
    end
  end

  assign addr_o = addr_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/strided_lane.sv
module strided_lane
  import strided_pkg::*;
(
  input  ew_e         ew_i,
  input  logic [2:0]  off_i,
  input  logic [63:0] st_elem_i,
  input  logic [63:0] rdata_i,
  output logic [7:0]  be_o,
  output logic [63:0] wdata_o,
  output logic [63:0] ld_elem_o,
  output logic        misalign_o
);
  logic [7:0]  be_base;
  logic [63:0] wmask;
  logic [5:0]  sh;

  always_comb begin
    case (ew_i)
      EW8:     begin be_base = 8'h01; wmask = 64'h0000_0000_0000_00FF; misalign_o = 1'b0;        end
      EW16:    begin be_base = 8'h03; wmask = 64'h0000_0000_0000_FFFF; misalign_o = off_i[0];    end
      EW32:    begin be_base = 8'h0F; wmask = 64'h0000_0000_FFFF_FFFF; misalign_o = |off_i[1:0]; end
      default: begin be_base = 8'hFF; wmask = '1;                      misalign_o = |off_i;      end
    endcase
  end

  assign sh        = {off_i, 3'b000};
  assign be_o      = be_base << off_i;
  assign wdata_o   = st_elem_i << sh;
  assign ld_elem_o = (rdata_i >> sh) & wmask;
endmodule

// File: rtl/strided_vreg.sv
module strided_vreg
  import strided_pkg::*;
#(
  parameter int MAX_VL = 16,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int VEC_W = MAX_VL * 64,
  localparam int NB    = MAX_VL * 8,
  localparam int BI_W  = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [VEC_W-1:0]  init_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  ew_e               ew_i,
  input  logic [63:0]       elem_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic [63:0]       elem_o
);
  logic [7:0]      byte_q [NB];
  logic [7:0]      byte_d [NB];
  logic [BI_W-1:0] base_b;
  logic [3:0]      nb;

  assign base_b = BI_W'(idx_i) << ew_i;
  assign nb     = 4'd1 << ew_i;

  always_comb begin
    for (int b = 0; b < NB; b++) byte_d[b] = byte_q[b];
    if (load_i) begin
      for (int b = 0; b < NB; b++) byte_d[b] = init_i[8*b +: 8];
    end else if (wr_i) begin
      for (int j = 0; j < 8; j++)
        if (4'(j) < nb) byte_d[base_b + BI_W'(j)] = elem_i[8*j +: 8];
    end
  end

  always_comb begin
    elem_o = '0;
    for (int j = 0; j < 8; j++)
      if (4'(j) < nb) elem_o[8*j +: 8] = byte_q[base_b + BI_W'(j)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NB; b++) byte_q[b] <= '0;
    end else begin
      for (int b = 0; b < NB; b++) byte_q[b] <= byte_d[b];
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_out
    assign vec_o[8*g +: 8] = byte_q[g];
  end
endmodule

// File: rtl/strided_vec_seq.sv
module strided_vec_seq
  import strided_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MAX_VL = 16,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int VEC_W = MAX_VL * 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              is_store_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [1:0]        ew_i,
  input  logic              mask_en_i,
  input  logic [MAX_VL-1:0] mask_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_we_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [7:0]        req_be_o,
  output logic [63:0]       req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic [63:0]       rsp_rdata_i
);
  seq_st_e           state_q, state_d;
  logic              st_q, men_q, done_q, err_q;
  ew_e               ew_q;
  logic [MAX_VL-1:0] mask_q;
  logic [VL_W-1:0]   vl_q;
  logic [ADDR_W-1:0] stride_q;

  logic              accept, step, finish, fail, wr;
  logic [ADDR_W-1:0] addr;
  logic [IDX_W-1:0]  idx;
  logic              last, active, misalign;
  logic [63:0]       st_elem, ld_elem;

  assign accept = start_i && (state_q == S_IDLE);
  assign last   = (VL_W'(idx) + VL_W'(1)) == vl_q;
  assign active = !men_q || mask_q[idx];

  strided_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_agen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .base_i   (base_addr_i),
    .stride_i (stride_q),
    .step_i   (step),
    .addr_o   (addr),
    .idx_o    (idx)
  );

  strided_lane u_lane (
    .ew_i       (ew_q),
    .off_i      (addr[2:0]),
    .st_elem_i  (st_elem),
    .rdata_i    (rsp_rdata_i),
    .be_o       (req_be_o),
    .wdata_o    (req_wdata_o),
    .ld_elem_o  (ld_elem),
    .misalign_o (misalign)
  );

  strided_vreg #(.MAX_VL(MAX_VL)) u_vreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .init_i (vec_i),
    .wr_i   (wr),
    .idx_i  (idx),
    .ew_i   (ew_q),
    .elem_i (ld_elem),
    .vec_o  (vec_o),
    .elem_o (st_elem)
  );

  always_comb begin
    state_d     = state_q;
    req_valid_o = 1'b0;
    step        = 1'b0;
    finish      = 1'b0;
    fail        = 1'b0;
    wr          = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (accept) begin
          if (vl_i == '0) finish = 1'b1;
          else            state_d = S_ISSUE;
        end
      end
      S_ISSUE: begin
        if (!active) begin
          if (last) finish = 1'b1;
          else      step = 1'b1;
        end else if (misalign) begin
          fail   = 1'b1;
          finish = 1'b1;
        end else begin
          req_valid_o = 1'b1;
          if (req_ready_i) begin
            if (!st_q)     state_d = S_WAIT;
            else if (last) finish = 1'b1;
            else           step = 1'b1;
          end
        end
      end
      S_WAIT: begin
        if (rsp_valid_i) begin
          wr = 1'b1;
          if (last) finish = 1'b1;
          else begin
            step    = 1'b1;
            state_d = S_ISSUE;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (finish) state_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      st_q     <= 1'b0;
      men_q    <= 1'b0;
      ew_q     <= EW8;
      mask_q   <= '0;
      vl_q     <= '0;
      stride_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (accept) begin
        st_q     <= is_store_i;
        men_q    <= mask_en_i;
        ew_q     <= ew_e'(ew_i);
        mask_q   <= mask_i;
        vl_q     <= vl_i;
        stride_q <= stride_i;
        err_q    <= 1'b0;
      end else if (fail) begin
        err_q <= 1'b1;
      end
    end
  end

  assign busy_o     = state_q != S_IDLE;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign req_we_o   = st_q;
  assign req_addr_o = addr;
endmodule

// File: rtl/strided_seq_chk.sv
module strided_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic              req_we_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [7:0]        req_be_o,
  input logic [63:0]       req_wdata_o,
  input logic              rsp_valid_i
);
  logic ld_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       ld_pend_q <= 1'b0;
    else if (req_valid_o && req_ready_i && !req_we_o)  ld_pend_q <= 1'b1;
    else if (rsp_valid_i)                              ld_pend_q <= 1'b0;
  end

  p_single_outstanding_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_pend_q |-> !req_valid_o);

  p_be_lane_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_be_o[req_addr_o[2:0]] &&
                    ((req_be_o & ((8'd1 << req_addr_o[2:0]) - 8'd1)) == 8'd0));

  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) &&
                                     $stable(req_be_o) && $stable(req_we_o) &&
                                     $stable(req_wdata_o));

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !done_o);

  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_err_at_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
endmodule

bind strided_vec_seq strided_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_we_o    (req_we_o),
  .req_addr_o  (req_addr_o),
  .req_be_o    (req_be_o),
  .req_wdata_o (req_wdata_o),
  .rsp_valid_i (rsp_valid_i)
);

// File: tb/tb_strided_vec_seq.sv
module tb_strided_vec_seq;
  localparam int ADDR_W = 32;
  localparam int MAX_VL = 16;
  localparam int VEC_W  = MAX_VL * 64;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0, is_store_i = 1'b0, mask_en_i = 1'b0;
  logic [ADDR_W-1:0] base_addr_i = '0, stride_i = '0;
  logic [4:0]        vl_i = '0;
  logic [1:0]        ew_i = '0;
  logic [MAX_VL-1:0] mask_i = '0;
  logic [VEC_W-1:0]  vec_i = '0;
  logic [VEC_W-1:0]  vec_o;
  logic              busy_o, done_o, err_o;
  logic              req_valid_o, req_we_o;
  logic              req_ready_i = 1'b0, rsp_valid_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_o;
  logic [7:0]        req_be_o;
  logic [63:0]       req_wdata_o, rsp_rdata_i = '0;

  always #2.5 clk = ~clk;

  strided_vec_seq #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .is_store_i(is_store_i),
    .base_addr_i(base_addr_i), .stride_i(stride_i), .vl_i(vl_i), .ew_i(ew_i),
    .mask_en_i(mask_en_i), .mask_i(mask_i), .vec_i(vec_i), .vec_o(vec_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_we_o(req_we_o),
    .req_addr_o(req_addr_o), .req_be_o(req_be_o), .req_wdata_o(req_wdata_o),
    .rsp_valid_i(rsp_valid_i), .rsp_rdata_i(rsp_rdata_i)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0]  mem [256];
  logic [31:0] log_addr [512];
  logic [7:0]  log_be [512];
  int log_n = 0;
  int stall_cfg = 0;
  int r8_viol = 0, r12_viol = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_elem(input logic [31:0] a, input int nb);
    logic [63:0] r = '0;
    for (int j = 0; j < nb; j++) r[8*j +: 8] = mem[8'(a + 32'(j))];
    return r;
  endfunction

  function automatic logic [63:0] vget(input logic [VEC_W-1:0] v, input int i, input int nb);
    logic [63:0] r = '0;
    for (int j = 0; j < nb; j++) r[8*j +: 8] = v[(i*nb + j)*8 +: 8];
    return r;
  endfunction

  // memory model: optional ready stall, load response one cycle after handshake
  initial begin
    logic        seen = 1'b0, ld_pend = 1'b0;
    logic [63:0] pend = '0;
    logic [31:0] s_addr = '0;
    logic [7:0]  s_be = '0;
    logic [63:0] s_wd = '0;
    int          wait_left = 0;
    forever begin
      @(negedge clk);
      rsp_valid_i = 1'b0;
      if (ld_pend) begin
        if (req_valid_o) r8_viol++;
        rsp_valid_i = 1'b1;
        rsp_rdata_i = pend;
        ld_pend = 1'b0;
      end
      if (req_ready_i) req_ready_i = 1'b0;
      else if (req_valid_o) begin
        if (!seen) begin
          seen = 1'b1; s_addr = req_addr_o; s_be = req_be_o; s_wd = req_wdata_o;
          wait_left = stall_cfg;
        end else if (s_addr !== req_addr_o || s_be !== req_be_o || s_wd !== req_wdata_o) begin
          r12_viol++;
        end
        if (wait_left > 0) wait_left--;
        else begin
          log_addr[log_n % 512] = req_addr_o;
          log_be[log_n % 512]   = req_be_o;
          log_n++;
          for (int k = 0; k < 8; k++) begin
            if (req_we_o && req_be_o[k]) mem[8'({req_addr_o[31:3], 3'b000} + 32'(k))] = req_wdata_o[8*k +: 8];
            pend[8*k +: 8] = mem[8'({req_addr_o[31:3], 3'b000} + 32'(k))];
          end
          if (!req_we_o) ld_pend = 1'b1;
          seen = 1'b0;
          req_ready_i = 1'b1;
        end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic run_cmd(input bit st, input logic [31:0] base, input logic [31:0] stride,
                         input int vl, input int ew, input bit men, input logic [15:0] msk,
                         output int n0, output int cyc);
    n0 = log_n;
    is_store_i = st; base_addr_i = base; stride_i = stride; vl_i = 5'(vl);
    ew_i = 2'(ew); mask_en_i = men; mask_i = msk;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    while (!done_o && cyc < 3000) begin @(negedge clk); cyc++; end
    chk("R11 done reached", 64'(done_o), 64'd1);
    chk("R11 busy low at done", 64'(busy_o), 64'd0);
    @(negedge clk);
    chk("R11 done one cycle", 64'(done_o), 64'd0);
  endtask

  task automatic t_reset();
    chk("R11 reset busy", 64'(busy_o), 64'd0);
    chk("R11 reset done", 64'(done_o), 64'd0);
    chk("R7 reset err", 64'(err_o), 64'd0);
    chk("R8 reset req_valid", 64'(req_valid_o), 64'd0);
  endtask

  task automatic t_load_pos();
    int n0, cyc;
    vec_i = '0;
    run_cmd(0, 32'h10, 32'd3, 4, 0, 0, '0, n0, cyc);
    chk("R1 request count", 64'(log_n - n0), 64'd4);
    for (int i = 0; i < 4; i++) begin
      chk("R1 byte stride address", 64'(log_addr[n0 + i]), 64'(32'h10 + 32'(3 * i)));
      chk("R1 loaded byte", vget(vec_o, i, 1), mem_elem(32'h10 + 32'(3 * i), 1));
    end
  endtask

  task automatic t_load_widths();
    int n0, cyc;
    run_cmd(0, 32'h20, 32'd4, 4, 1, 0, '0, n0, cyc);
    for (int i = 0; i < 4; i++) chk("R4 16-bit element", vget(vec_o, i, 2), mem_elem(32'h20 + 32'(4 * i), 2));
    chk("R5 byte enable 16-bit at offset 4", 64'(log_be[n0 + 1]), 64'h30);
    run_cmd(0, 32'h40, 32'd8, 4, 2, 0, '0, n0, cyc);
    for (int i = 0; i < 4; i++) chk("R4 32-bit element", vget(vec_o, i, 4), mem_elem(32'h40 + 32'(8 * i), 4));
    run_cmd(0, 32'h08, 32'd40, 2, 3, 0, '0, n0, cyc);
    chk("R4 64-bit stride 40 address", 64'(log_addr[n0 + 1]), 64'h30);
    chk("R4 64-bit element 0", vget(vec_o, 0, 8), mem_elem(32'h08, 8));
    chk("R4 64-bit element 1", vget(vec_o, 1, 8), mem_elem(32'h30, 8));
    chk("R5 byte enable 64-bit", 64'(log_be[n0]), 64'hFF);
  endtask

  task automatic t_load_neg();
    int n0, cyc;
    stall_cfg = 2;
    run_cmd(0, 32'h4E, 32'hFFFF_FFFC, 4, 1, 0, '0, n0, cyc);
    stall_cfg = 0;
    for (int i = 0; i < 4; i++) begin
      chk("R2 downward address", 64'(log_addr[n0 + i]), 64'(32'h4E - 32'(4 * i)));
      chk("R2 downward element", vget(vec_o, i, 2), mem_elem(32'h4E - 32'(4 * i), 2));
    end
    chk("R5 byte enable offset 6", 64'(log_be[n0]), 64'hC0);
  endtask

  task automatic t_zero_stride();
    int n0, cyc;
    run_cmd(0, 32'h33, 32'd0, 16, 0, 0, '0, n0, cyc);
    chk("R3 one access per element", 64'(log_n - n0), 64'd16);
    for (int i = 0; i < 16; i++) chk("R3 same value", vget(vec_o, i, 1), 64'(mem[8'h33]));
    chk("R3 same address", 64'(log_addr[n0 + 15]), 64'h33);
  endtask

  task automatic t_unit();
    int n0, cyc;
    run_cmd(0, 32'h60, 32'd4, 4, 2, 0, '0, n0, cyc);
    for (int b = 0; b < 16; b++) chk("R4 contiguous packing", 64'(vec_o[8*b +: 8]), 64'(mem[8'(8'h60 + b)]));
  endtask

  task automatic t_mask_load();
    int n0, cyc;
    for (int b = 0; b < MAX_VL * 8; b++) vec_i[8*b +: 8] = 8'h5A;
    run_cmd(0, 32'h10, 32'd3, 8, 0, 1, 16'h00AA, n0, cyc);
    chk("R6 masked load requests", 64'(log_n - n0), 64'd4);
    for (int i = 0; i < 8; i++)
      chk("R6 masked load element", vget(vec_o, i, 1),
          (i % 2 == 1) ? mem_elem(32'h10 + 32'(3 * i), 1) : 64'h5A);
    chk("R6 elements past vl untouched", vget(vec_o, 9, 1), 64'h5A);
  endtask

  task automatic t_store();
    int n0, cyc;
    logic [7:0] src [4] = '{8'h9F, 8'hE4, 8'h19, 8'h20};
    for (int k = 8'h80; k < 8'hC0; k++) mem[k] = 8'h00;
    vec_i = '0;
    for (int i = 0; i < 4; i++) vec_i[8*i +: 8] = src[i];
    run_cmd(1, 32'h80, 32'd3, 4, 0, 0, '0, n0, cyc);
    for (int i = 0; i < 4; i++) chk("R5 stored byte", 64'(mem[8'(8'h80 + 3 * i)]), 64'(src[i]));
    chk("R5 gap byte untouched", 64'(mem[8'h81]), 64'h00);
    chk("R5 store byte enable offset 3", 64'(log_be[n0 + 1]), 64'h08);
    vec_i[63:0]   = 64'h1122_3344_5566_7788;
    vec_i[127:64] = 64'h99AA_BBCC_DDEE_F001;
    stall_cfg = 3;
    run_cmd(1, 32'hA0, 32'd16, 2, 3, 0, '0, n0, cyc);
    stall_cfg = 0;
    chk("R4 64-bit store element 0", mem_elem(32'hA0, 8), 64'h1122_3344_5566_7788);
    chk("R4 64-bit store element 1", mem_elem(32'hB0, 8), 64'h99AA_BBCC_DDEE_F001);
    chk("R4 64-bit store gap", mem_elem(32'hA8, 8), 64'h0);
  endtask

  task automatic t_mask_store();
    int n0, cyc;
    for (int k = 8'hC0; k < 8'hD0; k++) mem[k] = 8'h77;
    vec_i = '0;
    vec_i[63:0] = 64'h4444_3333_2222_1111;
    run_cmd(1, 32'hC0, 32'd4, 4, 1, 1, 16'h0005, n0, cyc);
    chk("R6 masked store requests", 64'(log_n - n0), 64'd2);
    chk("R6 active element 0", mem_elem(32'hC0, 2), 64'h1111);
    chk("R6 inactive element 1 kept", mem_elem(32'hC4, 2), 64'h7777);
    chk("R6 active element 2", mem_elem(32'hC8, 2), 64'h3333);
    chk("R6 inactive element 3 kept", mem_elem(32'hCC, 2), 64'h7777);
  endtask

  task automatic t_misalign();
    int n0, cyc;
    run_cmd(0, 32'h12, 32'd4, 4, 2, 0, '0, n0, cyc);
    chk("R7 misaligned first element flag", 64'(err_o), 64'd1);
    chk("R7 no request issued", 64'(log_n - n0), 64'd0);
    run_cmd(0, 32'h10, 32'd6, 4, 2, 0, '0, n0, cyc);
    chk("R7 stops at misaligned element", 64'(log_n - n0), 64'd1);
    chk("R7 flag after late misalign", 64'(err_o), 64'd1);
    run_cmd(0, 32'h12, 32'd4, 2, 2, 1, 16'h0000, n0, cyc);
    chk("R7 inactive misaligned element no error", 64'(err_o), 64'd0);
  endtask

  task automatic t_vl0();
    int n0, cyc;
    run_cmd(0, 32'h10, 32'd1, 0, 0, 0, '0, n0, cyc);
    chk("R9 done in next cycle", 64'(cyc), 64'd0);
    chk("R9 no access", 64'(log_n - n0), 64'd0);
  endtask

  task automatic t_busy_start();
    int n0, cyc;
    fork
      run_cmd(0, 32'h20, 32'd1, 4, 0, 0, '0, n0, cyc);
      begin
        repeat (3) @(negedge clk);
        base_addr_i = 32'h80;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
      end
    join
    chk("R10 request count unchanged", 64'(log_n - n0), 64'd4);
    for (int i = 0; i < 4; i++) chk("R10 address unaffected", 64'(log_addr[n0 + i]), 64'(32'h20 + 32'(i)));
    chk("R10 data from first command", vget(vec_o, 3, 1), mem_elem(32'h23, 1));
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 8'(k * 37 + 11);
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_load_pos();
    t_load_widths();
    t_load_neg();
    t_zero_stride();
    t_unit();
    t_mask_load();
    t_store();
    t_mask_store();
    t_misalign();
    t_vl0();
    t_busy_start();
    chk("R8 no request while load in flight", 64'(r8_viol), 64'd0);
    chk("R12 request held during stall", 64'(r12_viol), 64'd0);
    finish_run();
  end
endmodule